// File: doc/BRIEF.md
# Checkpointing Register File

This block is a multi-ported register file whose whole contents can be saved into one of several checkpoint slots in a single cycle and brought back from any slot, again in one cycle. A typical user is a speculative pipeline. It saves the array at a branch, keeps writing, and restores the saved image when the speculation turns out wrong.

Read ports are combinational. An optional forwarding path lets a read see a write to the same register in the same cycle. A debug path shows every register at once on a wide dump bus. A load strobe overwrites every register from a wide input bus in one cycle. The number of read ports, write ports, checkpoint slots, the depth and the data width are all parameters.

When several sources try to change the array in one cycle, they are ranked. A restore beats a parallel load. A parallel load beats ordinary writes. Among ordinary writes to the same register, the highest-numbered port wins.

Top module: `ckpt_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, every register and every checkpoint slot becomes zero.
- R2: A write on port p with `wr_en[p]`=1 updates the register at `wr_addr` from the next cycle. With forwarding disabled, a same-cycle read of that register returns the old value.
- R3: With `BYPASS`=1, a read of a register being written in the same cycle returns the write data. This forwarding applies only when neither `load_en` nor `set_en` is high in that cycle; otherwise the read returns the stored value.
- R4: When several write ports target the same register in one cycle, the highest-numbered enabled port determines the stored value.
- R5: `save_en` copies into slot `save_slot` the array as it stands after that cycle's update, so a same-cycle write is included.
- R6: `load_en` replaces the array with the contents of slot `load_slot`, visible on reads and dump from the next cycle. Writes made after the save are discarded.
- R7: A restore takes priority over a same-cycle write and over a same-cycle parallel set.
- R8: `set_en` loads register i from `set_data[i*DATA_W +: DATA_W]`, visible from the next cycle. It takes priority over same-cycle writes.
- R9: `dump_data[i*DATA_W +: DATA_W]` always shows the current value of register i.
- R10: Saving into one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | RD_PORTS*AW | Read addresses, port k in bits [k*AW +: AW] |
| rd_data | output | RD_PORTS*DATA_W | Read data, port k in bits [k*DATA_W +: DATA_W] |
| wr_en | input | WR_PORTS | Per-port write enable |
| wr_addr | input | WR_PORTS*AW | Write addresses, port p in bits [p*AW +: AW] |
| wr_data | input | WR_PORTS*DATA_W | Write data, port p in bits [p*DATA_W +: DATA_W] |
| save_en | input | 1 | Copy the updated array into a slot |
| save_slot | input | SW | Slot written by a save |
| load_en | input | 1 | Restore the array from a slot |
| load_slot | input | SW | Slot read by a restore |
| set_en | input | 1 | Load every register from set_data |
| set_data | input | DEPTH*DATA_W | Parallel load values, register i in bits [i*DATA_W +: DATA_W] |
| dump_data | output | DEPTH*DATA_W | Current value of every register |

## Verification
The hardest case is the collision of a save, later writes and a restore. Showing that writes were discarded needs a save that already contains a same-cycle write. Later writes must then diverge from that image, and the restore must arrive together with yet another write and a read of the register being written. The bench builds this in three consecutive cycles, then stacks a restore on a parallel set. It also saves a second, differing image so that restoring one slot proves the other was left untouched. Two instances, with and without forwarding, share all stimulus so that the same-cycle read is compared both ways.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;

    typedef enum logic [1:0] {
        NEXT_HOLD    = 2'd0,
        NEXT_WRITE   = 2'd1,
        NEXT_SET     = 2'd2,
        NEXT_RESTORE = 2'd3
    } next_src_e;

    // Ranking of sources that may change the array in one cycle.
    function automatic next_src_e pick_source(input logic restore,
                                              input logic set,
                                              input logic any_write);
        if (restore)        return NEXT_RESTORE;
        else if (set)       return NEXT_SET;
        else if (any_write) return NEXT_WRITE;
        else                return NEXT_HOLD;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ckpt_write_merge.sv
module ckpt_write_merge
    import ckpt_rf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int WR_PORTS = 2,
    parameter int AW       = 2
) (
    input  logic [DEPTH-1:0][DATA_W-1:0]    cur,
    input  logic [WR_PORTS-1:0]             wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0]     wr_addr,
    input  logic [WR_PORTS-1:0][DATA_W-1:0] wr_data,
    input  logic                            set_en,
    input  logic [DEPTH-1:0][DATA_W-1:0]    set_vals,
    input  logic                            restore_en,
    input  logic [DEPTH-1:0][DATA_W-1:0]    restore_vals,
    output logic [DEPTH-1:0][DATA_W-1:0]    nxt,
    output next_src_e                       src
);

    logic [DEPTH-1:0][DATA_W-1:0] written;

    // Later ports overwrite earlier ones: highest-numbered port wins.
    always_comb begin
        written = cur;
        for (int p = 0; p < WR_PORTS; p++) begin
            if (wr_en[p] && (int'(wr_addr[p]) < DEPTH)) begin
                written[wr_addr[p]] = wr_data[p];
            end
        end
    end

    assign src = pick_source(restore_en, set_en, |wr_en);

    always_comb begin
        unique case (src)
            NEXT_RESTORE: nxt = restore_vals;
            NEXT_SET:     nxt = set_vals;
            NEXT_WRITE:   nxt = written;
            default:      nxt = cur;
        endcase
    end

endmodule

// File: rtl/ckpt_slot_bank.sv
module ckpt_slot_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int SLOTS  = 2,
    parameter int SW     = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         save_en,
    input  logic [SW-1:0]                save_slot,
    input  logic [DEPTH-1:0][DATA_W-1:0] save_vals,
    input  logic [SW-1:0]                load_slot,
    output logic [DEPTH-1:0][DATA_W-1:0] load_vals
);

    logic [DEPTH-1:0][DATA_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (save_en && (int'(save_slot) == g)) begin
                slot_q[g] <= save_vals;
            end
        end

        // R10
        other_slot_kept_chk: assert property (@(posedge clk) disable iff (rst)
            !(save_en && (int'(save_slot) == g)) |=> $stable(slot_q[g]));
    end

    always_comb begin
        load_vals = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(load_slot) == s) load_vals = slot_q[s];
        end
    end

    // R5
    save_captures_chk: assert property (@(posedge clk) disable iff (rst)
        (save_en && (int'(save_slot) < SLOTS)) |=> slot_q[$past(save_slot)] == $past(save_vals));

endmodule

// File: rtl/ckpt_read_port.sv
module ckpt_read_port #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int WR_PORTS = 2,
    parameter int AW       = 2,
    parameter bit BYPASS   = 1'b1
) (
    input  logic [DEPTH-1:0][DATA_W-1:0]    cur,
    input  logic [AW-1:0]                   rd_addr,
    input  logic [WR_PORTS-1:0]             wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0]     wr_addr,
    input  logic [WR_PORTS-1:0][DATA_W-1:0] wr_data,
    input  logic                            fwd_ok,
    output logic [DATA_W-1:0]               rd_data
);

    logic [DATA_W-1:0] stored;

    assign stored = (int'(rd_addr) < DEPTH) ? cur[rd_addr] : '0;

    if (BYPASS) begin : g_fwd
        always_comb begin
            rd_data = stored;
            if (fwd_ok) begin
                for (int p = 0; p < WR_PORTS; p++) begin
                    if (wr_en[p] && (wr_addr[p] == rd_addr)) rd_data = wr_data[p];
                end
            end
        end
    end else begin : g_plain
        logic unused_fwd;
        assign unused_fwd = fwd_ok ^ (^wr_en) ^ (^wr_addr) ^ (^wr_data);
        assign rd_data = stored;
    end

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
    import ckpt_rf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int RD_PORTS = 2,
    parameter int WR_PORTS = 2,
    parameter int SLOTS    = 2,
    parameter bit BYPASS   = 1'b1,
    localparam int AW      = idx_width(DEPTH),
    localparam int SW      = idx_width(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RD_PORTS*AW-1:0]       rd_addr,
    output logic [RD_PORTS*DATA_W-1:0]   rd_data,
    input  logic [WR_PORTS-1:0]          wr_en,
    input  logic [WR_PORTS*AW-1:0]       wr_addr,
    input  logic [WR_PORTS*DATA_W-1:0]   wr_data,
    input  logic                         save_en,
    input  logic [SW-1:0]                save_slot,
    input  logic                         load_en,
    input  logic [SW-1:0]                load_slot,
    input  logic                         set_en,
    input  logic [DEPTH*DATA_W-1:0]      set_data,
    output logic [DEPTH*DATA_W-1:0]      dump_data
);

    logic [DEPTH-1:0][DATA_W-1:0]    regs_q;
    logic [DEPTH-1:0][DATA_W-1:0]    regs_nxt;
    logic [DEPTH-1:0][DATA_W-1:0]    set_vals;
    logic [DEPTH-1:0][DATA_W-1:0]    slot_vals;
    logic [WR_PORTS-1:0][AW-1:0]     wa;
    logic [WR_PORTS-1:0][DATA_W-1:0] wd;
    next_src_e                       src;
    logic                            fwd_ok;

    assign set_vals  = set_data;
    assign wa        = wr_addr;
    assign wd        = wr_data;
    assign dump_data = regs_q;
    assign fwd_ok    = !load_en && !set_en;

    ckpt_write_merge #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .WR_PORTS(WR_PORTS), .AW(AW)
    ) u_merge (
        .cur(regs_q), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd),
        .set_en(set_en), .set_vals(set_vals),
        .restore_en(load_en), .restore_vals(slot_vals),
        .nxt(regs_nxt), .src(src)
    );

    ckpt_slot_bank #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .SLOTS(SLOTS), .SW(SW)
    ) u_slots (
        .clk(clk), .rst(rst), .save_en(save_en), .save_slot(save_slot),
        .save_vals(regs_nxt), .load_slot(load_slot), .load_vals(slot_vals)
    );

    for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
        ckpt_read_port #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .WR_PORTS(WR_PORTS), .AW(AW), .BYPASS(BYPASS)
        ) u_rd (
            .cur(regs_q), .rd_addr(rd_addr[k*AW +: AW]),
            .wr_en(wr_en), .wr_addr(wa), .wr_data(wd), .fwd_ok(fwd_ok),
            .rd_data(rd_data[k*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (src != NEXT_HOLD) begin
            regs_q <= regs_nxt;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> regs_q == '0);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !set_en && !(|wr_en)) |=> $stable(regs_q));

    // R4
    top_port_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en[WR_PORTS-1] && !load_en && !set_en && (int'(wa[WR_PORTS-1]) < DEPTH))
        |=> regs_q[$past(wa[WR_PORTS-1])] == $past(wd[WR_PORTS-1]));

    // R6
    restore_applies_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> regs_q == $past(slot_vals));

    // R8
    set_applies_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !load_en) |=> regs_q == $past(set_vals));

endmodule

// File: tb/ckpt_regfile_tb.sv
module ckpt_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data, rd_data_nb;
    logic [1:0]  wr_en = '0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        save_en = 1'b0;
    logic [0:0]  save_slot = '0;
    logic        load_en = 1'b0;
    logic [0:0]  load_slot = '0;
    logic        set_en = 1'b0;
    logic [31:0] set_data = '0;
    logic [31:0] dump_data, dump_nb;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ckpt_regfile #(.BYPASS(1'b1)) u_dut (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_en(save_en), .save_slot(save_slot), .load_en(load_en),
        .load_slot(load_slot), .set_en(set_en), .set_data(set_data),
        .dump_data(dump_data)
    );

    ckpt_regfile #(.BYPASS(1'b0)) u_nb (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data_nb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_en(save_en), .save_slot(save_slot), .load_en(load_en),
        .load_slot(load_slot), .set_en(set_en), .set_data(set_data),
        .dump_data(dump_nb)
    );

    // {we0, wa0, wd0, we1, wa1, wd1, ra0, ra1, exp_rd0, exp_rd1} for the forwarding instance
    localparam int NV = 6;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'h11, 1'b0, 2'd0, 8'h00, 2'd1, 2'd2, 8'h11, 8'h00},
        {1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 8'h22, 2'd1, 2'd2, 8'h11, 8'h22},
        {1'b1, 2'd3, 8'h33, 1'b1, 2'd3, 8'h44, 2'd3, 2'd0, 8'h44, 8'h00},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd3, 2'd2, 8'h44, 8'h22},
        {1'b1, 2'd0, 8'h55, 1'b0, 2'd0, 8'h00, 2'd0, 2'd1, 8'h55, 8'h11},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd0, 2'd3, 8'h55, 8'h44}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = '0; save_en = 1'b0; load_en = 1'b0; set_en = 1'b0;
    endtask

    task automatic run_all();
        // R1: reset state
        idle();
        repeat (2) @(negedge clk);
        check("R1 dump after reset", dump_data, 32'h0);
        check("R1 read after reset", {16'h0, rd_data}, 32'h0);
        rst = 1'b0;

        // R2 R3 R4: vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            wr_en   = {VEC[i][30], VEC[i][41]};
            wr_addr = {VEC[i][29:28], VEC[i][40:39]};
            wr_data = {VEC[i][27:20], VEC[i][38:31]};
            rd_addr = {VEC[i][17:16], VEC[i][19:18]};
            #5;
            check("R3 R4 vector rd0", {24'h0, rd_data[7:0]}, {24'h0, VEC[i][15:8]});
            check("R2 R4 vector rd1", {24'h0, rd_data[15:8]}, {24'h0, VEC[i][7:0]});
        end

        // R9: dump shows every register
        @(negedge clk);
        idle();
        check("R9 dump", dump_data, 32'h44221155);
        check("R9 dump no-fwd", dump_nb, 32'h44221155);

        // R2 / R3: same-cycle read with and without forwarding
        wr_en = 2'b01; wr_addr = {2'd0, 2'd2}; wr_data = {8'h00, 8'h66}; rd_addr = {2'd0, 2'd2};
        #5;
        check("R3 forwarded read", {24'h0, rd_data[7:0]}, 32'h66);
        check("R2 no-fwd old value", {24'h0, rd_data_nb[7:0]}, 32'h22);
        @(negedge clk);
        idle();
        #5;
        check("R2 no-fwd next cycle", {24'h0, rd_data_nb[7:0]}, 32'h66);

        // R5: save with same-cycle write
        @(negedge clk);
        wr_en = 2'b01; wr_addr = {2'd0, 2'd1}; wr_data = {8'h00, 8'h77};
        save_en = 1'b1; save_slot = 1'b0;
        @(negedge clk);
        idle();
        wr_en = 2'b11; wr_addr = {2'd0, 2'd1}; wr_data = {8'h99, 8'h88};
        @(negedge clk);
        idle();
        check("R2 writes landed", dump_data, 32'h44668899);
        // R6 R7: restore with a same-cycle write, forwarding suppressed
        load_en = 1'b1; load_slot = 1'b0;
        wr_en = 2'b01; wr_addr = {2'd0, 2'd2}; wr_data = {8'h00, 8'hAA}; rd_addr = {2'd0, 2'd2};
        #5;
        check("R3 no forward during restore", {24'h0, rd_data[7:0]}, 32'h66);
        @(negedge clk);
        idle();
        check("R5 R6 R7 restored image", dump_data, 32'h44667755);

        // build a second, different image in slot 1
        wr_en = 2'b01; wr_addr = {2'd0, 2'd3}; wr_data = {8'h00, 8'hC3};
        @(negedge clk);
        idle();
        save_en = 1'b1; save_slot = 1'b1;
        @(negedge clk);
        idle();

        // R8: set beats write
        set_en = 1'b1; set_data = 32'h04030201;
        wr_en = 2'b01; wr_addr = {2'd0, 2'd0}; wr_data = {8'h00, 8'hEE};
        @(negedge clk);
        idle();
        check("R8 set loaded", dump_data, 32'h04030201);
        check("R8 set loaded no-fwd", dump_nb, 32'h04030201);

        // R7: restore beats set
        load_en = 1'b1; load_slot = 1'b0; set_en = 1'b1; set_data = 32'hDEADBEEF;
        @(negedge clk);
        idle();
        check("R7 restore over set", dump_data, 32'h44667755);

        // R10: slot 1 kept its own image
        load_en = 1'b1; load_slot = 1'b1;
        @(negedge clk);
        idle();
        rd_addr = {2'd0, 2'd3};
        #5;
        check("R10 slot1 image", dump_data, 32'hC3667755);
        check("R10 slot1 read", {24'h0, rd_data[7:0]}, 32'hC3);

        // R1: reset clears registers and slots
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 regs cleared", dump_data, 32'h0);
        load_en = 1'b1; load_slot = 1'b1;
        @(negedge clk);
        idle();
        check("R1 slot cleared", dump_data, 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule